// File: doc/BRIEF.md
# Operand-Capturing Reservation Pool

This block is a small set of reservation stations that serves one class of functional unit in a dynamically scheduled core. Instructions arrive in program order from an instruction queue. Each one takes a free station. Each of its two source operands is stored either as a value or as the tag of the station that will produce that value. A register status table maps every architectural register to the tag of its newest pending producer, so source registers are renamed to station tags when an instruction is accepted.

Results come back on one broadcast result bus, which carries a valid strobe, a producer tag and a data word. Every station waiting on that tag copies the data. The station that owns the tag is released in the same cycle. The register file is written only when the register's status entry still names that producer, so only the last writer of a register updates it. Each cycle, at most one station whose operands are both present is handed to the functional unit, and the unit accepts it unconditionally. The register file itself lives outside the block: the block supplies read addresses through the issue source fields, takes the read data back in the same cycle, and drives the write port.

Top module: `rs_pool`

## Requirements
- R1: `issueReady` is high exactly when at least one station is free. An issue presented while `issueReady` is low is ignored: no station is taken and no register is renamed.
- R2: An accepted instruction takes the lowest-numbered free station. Station i (counting from 0) owns tag i+1. Tag 0 means "value present" and is never the tag of a station.
- R3: At issue, a source register whose status is 0 has its value taken from the register-file read data for that source.
- R4: At issue, a source register with a pending producer records that producer's tag. The value is captured when that tag appears on the result bus.
- R5: A station is dispatched only when both of its operands are held. Each accepted instruction is dispatched exactly once, in the first cycle after its last operand is captured. `dispTag` names the station being dispatched.
- R6: When several stations are ready, the lowest-numbered one dispatches first.
- R7: If the producer of a source broadcasts in the same cycle that the consumer issues, the consumer takes the broadcast value at issue and does not wait.
- R8: A broadcast writes the register file (`rfWrEn`, `rfWrAddr` set to the producer's destination, `rfWrData` set to the bus data) only if that register's status still names the broadcasting tag. The status entry then returns to 0.
- R9: An accepted instruction overwrites its destination's status with its own tag. Later readers of that register wait for the newest producer, and older producers of that register no longer write it.
- R10: The station whose tag is broadcast is freed at that clock edge. `issueReady` rises in the following cycle when the pool had been full.
- R11: After reset every station is free, nothing dispatches and the register file is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction queue presents an instruction |
| issueOp | input | OP_W | Operation code carried to the functional unit |
| issueDst | input | REG_W | Destination architectural register |
| issueSrcA | input | REG_W | First source register (also the register-file read address A) |
| issueSrcB | input | REG_W | Second source register (also the register-file read address B) |
| issueReady | output | 1 | A station is free; the presented instruction is accepted |
| rfRdDataA | input | DATA_W | Register-file data for issueSrcA |
| rfRdDataB | input | DATA_W | Register-file data for issueSrcB |
| cdbValid | input | 1 | Result bus carries a result |
| cdbTag | input | TAG_W | Producer tag on the result bus |
| cdbData | input | DATA_W | Result value |
| dispValid | output | 1 | A ready station is dispatched this cycle |
| dispTag | output | TAG_W | Tag of the dispatched station |
| dispOp | output | OP_W | Operation code of the dispatched station |
| dispOpA | output | DATA_W | First operand value |
| dispOpB | output | DATA_W | Second operand value |
| rfWrEn | output | 1 | Register-file write enable |
| rfWrAddr | output | REG_W | Register-file write address |
| rfWrData | output | DATA_W | Register-file write data |

## Verification
The bench builds the block with four stations, eight registers and 16-bit data. With eight registers, every one of the 64 source-register pairs can be swept through the issue, dispatch and writeback path in a few cycles each. With four stations, the pool can be filled completely, so the stall, the release on broadcast and a three-way tie in dispatch priority can all be reached. The directed cases then cover a producer that is overtaken by a newer writer and a broadcast that lands in the same cycle as a dependent issue.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Widest slot index carried in the strobe struct; pools up to 16 stations.
  localparam int SLOT_IDX_W = 4;

  typedef struct packed {
    logic                  issueEn;
    logic [SLOT_IDX_W-1:0] issueSlot;
    logic                  dispEn;
    logic [SLOT_IDX_W-1:0] dispSlot;
  } rsStrobe_t;

endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int NUM_RS = 4
) (
  input  logic [NUM_RS-1:0] busyVec,
  input  logic [NUM_RS-1:0] readyVec,
  input  logic              issueValid,
  output logic              issueReady,
  output rsStrobe_t         strobe
);

  logic                  anyFree;
  logic                  anyReady;
  logic [SLOT_IDX_W-1:0] freeIdx;
  logic [SLOT_IDX_W-1:0] readyIdx;

  // Lowest-numbered free and ready stations: scan downward so the lowest wins.
  always_comb begin
    anyFree  = 1'b0;
    anyReady = 1'b0;
    freeIdx  = '0;
    readyIdx = '0;
    for (int i = NUM_RS - 1; i >= 0; i--) begin
      if (!busyVec[i]) begin
        anyFree = 1'b1;
        freeIdx = SLOT_IDX_W'(i);
      end
      if (readyVec[i]) begin
        anyReady = 1'b1;
        readyIdx = SLOT_IDX_W'(i);
      end
    end
  end

  assign issueReady       = anyFree;
  assign strobe.issueEn   = issueValid && anyFree;
  assign strobe.issueSlot = freeIdx;
  assign strobe.dispEn    = anyReady;
  assign strobe.dispSlot  = readyIdx;

endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 2,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int TAG_W   = $clog2(NUM_RS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strobe,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  input  logic [DATA_W-1:0] rfRdDataA,
  input  logic [DATA_W-1:0] rfRdDataB,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic [NUM_RS-1:0] busyVec,
  output logic [NUM_RS-1:0] readyVec,
  output logic              dispValid,
  output logic [TAG_W-1:0]  dispTag,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispOpA,
  output logic [DATA_W-1:0] dispOpB,
  output logic              rfWrEn,
  output logic [REG_W-1:0]  rfWrAddr,
  output logic [DATA_W-1:0] rfWrData
);

  localparam logic [TAG_W-1:0] NO_TAG = '0;

  logic [TAG_W-1:0]  regStatQ [NUM_REGS];
  logic [OP_W-1:0]   opArr    [NUM_RS];
  logic [REG_W-1:0]  dstArr   [NUM_RS];
  logic [DATA_W-1:0] valAArr  [NUM_RS];
  logic [DATA_W-1:0] valBArr  [NUM_RS];

  // Operand resolution at issue: register file, same-cycle bus, or a tag.
  logic [TAG_W-1:0]  statA, statB, newTagA, newTagB, issueTag;
  logic [DATA_W-1:0] newValA, newValB;
  logic              hitA, hitB;

  assign statA    = regStatQ[issueSrcA];
  assign statB    = regStatQ[issueSrcB];
  assign hitA     = cdbValid && (statA != NO_TAG) && (cdbTag == statA);
  assign hitB     = cdbValid && (statB != NO_TAG) && (cdbTag == statB);
  assign newValA  = (statA == NO_TAG) ? rfRdDataA : cdbData;
  assign newValB  = (statB == NO_TAG) ? rfRdDataB : cdbData;
  assign newTagA  = (statA == NO_TAG || hitA) ? NO_TAG : statA;
  assign newTagB  = (statB == NO_TAG || hitB) ? NO_TAG : statB;
  assign issueTag = TAG_W'(strobe.issueSlot) + TAG_W'(1);

  for (genvar g = 0; g < NUM_RS; g++) begin : gSlot
    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(g + 1);

    logic              busy, sent;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] valA, valB;
    logic [TAG_W-1:0]  tagA, tagB;
    logic              issueHere, dispHere, freeHere, capA, capB;

    assign issueHere = strobe.issueEn && (strobe.issueSlot == SLOT_IDX_W'(g));
    assign dispHere  = strobe.dispEn && (strobe.dispSlot == SLOT_IDX_W'(g));
    assign freeHere  = busy && cdbValid && (cdbTag == MY_TAG);
    assign capA      = busy && cdbValid && (tagA != NO_TAG) && (tagA == cdbTag);
    assign capB      = busy && cdbValid && (tagB != NO_TAG) && (tagB == cdbTag);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy <= 1'b0;
        sent <= 1'b0;
        op   <= '0;
        dst  <= '0;
        valA <= '0;
        valB <= '0;
        tagA <= NO_TAG;
        tagB <= NO_TAG;
      end else if (issueHere) begin
        busy <= 1'b1;
        sent <= 1'b0;
        op   <= issueOp;
        dst  <= issueDst;
        valA <= newValA;
        valB <= newValB;
        tagA <= newTagA;
        tagB <= newTagB;
      end else begin
        if (freeHere) busy <= 1'b0;
        if (dispHere) sent <= 1'b1;
        if (capA) begin
          valA <= cdbData;
          tagA <= NO_TAG;
        end
        if (capB) begin
          valB <= cdbData;
          tagB <= NO_TAG;
        end
      end
    end

    assign busyVec[g]  = busy;
    assign readyVec[g] = busy && !sent && (tagA == NO_TAG) && (tagB == NO_TAG);
    assign opArr[g]    = op;
    assign dstArr[g]   = dst;
    assign valAArr[g]  = valA;
    assign valBArr[g]  = valB;
  end

  // Register status table: a broadcast clears a matching entry, an issue renames.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regStatQ[r] <= NO_TAG;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (cdbValid && (cdbTag != NO_TAG) && (regStatQ[r] == cdbTag))
          regStatQ[r] <= NO_TAG;
        if (strobe.issueEn && (issueDst == REG_W'(r)))
          regStatQ[r] <= issueTag;
      end
    end
  end

  // Writeback gating: only the newest named producer reaches the register file.
  logic [REG_W-1:0] wbDst;
  logic             wbBusy;

  always_comb begin
    wbDst  = '0;
    wbBusy = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (cdbTag == TAG_W'(i + 1)) begin
        wbDst  = dstArr[i];
        wbBusy = busyVec[i];
      end
    end
  end

  assign rfWrEn   = cdbValid && wbBusy && (regStatQ[wbDst] == cdbTag);
  assign rfWrAddr = wbDst;
  assign rfWrData = cdbData;

  // Dispatch mux.
  always_comb begin
    dispOp  = '0;
    dispOpA = '0;
    dispOpB = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (strobe.dispSlot == SLOT_IDX_W'(i)) begin
        dispOp  = opArr[i];
        dispOpA = valAArr[i];
        dispOpB = valBArr[i];
      end
    end
  end

  assign dispValid = strobe.dispEn;
  assign dispTag   = TAG_W'(strobe.dispSlot) + TAG_W'(1);

endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 2,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int TAG_W   = $clog2(NUM_RS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueDst,
  input  logic [REG_W-1:0]  issueSrcA,
  input  logic [REG_W-1:0]  issueSrcB,
  output logic              issueReady,
  input  logic [DATA_W-1:0] rfRdDataA,
  input  logic [DATA_W-1:0] rfRdDataB,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic              dispValid,
  output logic [TAG_W-1:0]  dispTag,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispOpA,
  output logic [DATA_W-1:0] dispOpB,
  output logic              rfWrEn,
  output logic [REG_W-1:0]  rfWrAddr,
  output logic [DATA_W-1:0] rfWrData
);

  logic [NUM_RS-1:0] busyVec;
  logic [NUM_RS-1:0] readyVec;
  rsStrobe_t         strobe;

  rs_ctrl #(.NUM_RS(NUM_RS)) ctrl_i (
    .busyVec    (busyVec),
    .readyVec   (readyVec),
    .issueValid (issueValid),
    .issueReady (issueReady),
    .strobe     (strobe)
  );

  rs_datapath #(
    .NUM_RS   (NUM_RS),
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .OP_W     (OP_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .issueOp   (issueOp),
    .issueDst  (issueDst),
    .issueSrcA (issueSrcA),
    .issueSrcB (issueSrcB),
    .rfRdDataA (rfRdDataA),
    .rfRdDataB (rfRdDataB),
    .cdbValid  (cdbValid),
    .cdbTag    (cdbTag),
    .cdbData   (cdbData),
    .busyVec   (busyVec),
    .readyVec  (readyVec),
    .dispValid (dispValid),
    .dispTag   (dispTag),
    .dispOp    (dispOp),
    .dispOpA   (dispOpA),
    .dispOpB   (dispOpB),
    .rfWrEn    (rfWrEn),
    .rfWrAddr  (rfWrAddr),
    .rfWrData  (rfWrData)
  );

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int NUM_RS = 4,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic              issueReady,
  input logic              cdbValid,
  input logic [TAG_W-1:0]  cdbTag,
  input logic              dispValid,
  input logic [TAG_W-1:0]  dispTag,
  input logic              rfWrEn,
  input logic [NUM_RS-1:0] busyVec,
  input logic [NUM_RS-1:0] readyVec
);

  function automatic logic [NUM_RS-1:0] belowMask(input logic [TAG_W-1:0] t);
    logic [NUM_RS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_RS; i++) m[i] = (TAG_W'(i + 1) < t);
    return m;
  endfunction

  function automatic logic tagBusy(input logic [NUM_RS-1:0] v, input logic [TAG_W-1:0] t);
    logic b;
    b = 1'b0;
    for (int i = 0; i < NUM_RS; i++) if (t == TAG_W'(i + 1)) b = v[i];
    return b;
  endfunction

  // R1
  ready_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueReady == !(&busyVec));

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueReady && !cdbValid) |=> (busyVec == $past(busyVec)));

  // R2
  disp_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (dispTag != '0) && tagBusy(busyVec, dispTag));

  // R6
  disp_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> ((readyVec & belowMask(dispTag)) == '0));

  // R5
  disp_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> !(dispValid && (dispTag == $past(dispTag))));

  // R10
  free_on_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cdbValid && tagBusy(busyVec, cdbTag)) |=> !tagBusy(busyVec, $past(cdbTag)));

  // R8
  wb_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (cdbValid && tagBusy(busyVec, cdbTag)));

endmodule

bind rs_pool rs_pool_chk #(.NUM_RS(NUM_RS), .TAG_W(TAG_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .issueValid (issueValid),
  .issueReady (issueReady),
  .cdbValid   (cdbValid),
  .cdbTag     (cdbTag),
  .dispValid  (dispValid),
  .dispTag    (dispTag),
  .rfWrEn     (rfWrEn),
  .busyVec    (busyVec),
  .readyVec   (readyVec)
);

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_RS     = 4;
  localparam int NUM_REGS   = 8;
  localparam int DATA_W     = 16;
  localparam int OP_W       = 2;
  localparam int REG_W      = $clog2(NUM_REGS);
  localparam int TAG_W      = $clog2(NUM_RS + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              issueValid = 1'b0;
  logic [OP_W-1:0]   issueOp = '0;
  logic [REG_W-1:0]  issueDst = '0;
  logic [REG_W-1:0]  issueSrcA = '0;
  logic [REG_W-1:0]  issueSrcB = '0;
  logic              issueReady;
  logic [DATA_W-1:0] rfRdDataA, rfRdDataB;
  logic              cdbValid = 1'b0;
  logic [TAG_W-1:0]  cdbTag = '0;
  logic [DATA_W-1:0] cdbData = '0;
  logic              dispValid;
  logic [TAG_W-1:0]  dispTag;
  logic [OP_W-1:0]   dispOp;
  logic [DATA_W-1:0] dispOpA, dispOpB;
  logic              rfWrEn;
  logic [REG_W-1:0]  rfWrAddr;
  logic [DATA_W-1:0] rfWrData;

  logic [DATA_W-1:0] rfMem [NUM_REGS];
  logic [DATA_W-1:0] expRf [NUM_REGS];

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rs_pool #(.NUM_RS(NUM_RS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .OP_W(OP_W)) dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueOp(issueOp),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueReady(issueReady), .rfRdDataA(rfRdDataA), .rfRdDataB(rfRdDataB),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .dispValid(dispValid), .dispTag(dispTag), .dispOp(dispOp),
    .dispOpA(dispOpA), .dispOpB(dispOpB), .rfWrEn(rfWrEn),
    .rfWrAddr(rfWrAddr), .rfWrData(rfWrData)
  );

  // External register file model.
  assign rfRdDataA = rfMem[issueSrcA];
  assign rfRdDataB = rfMem[issueSrcB];
  always @(posedge clk) if (rfWrEn) rfMem[rfWrAddr] <= rfWrData;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepClr();
    @(posedge clk);
    #1;
    issueValid = 1'b0;
    cdbValid   = 1'b0;
  endtask

  task automatic putIssue(input int op, input int dst, input int sa, input int sb);
    issueValid = 1'b1;
    issueOp    = OP_W'(op);
    issueDst   = REG_W'(dst);
    issueSrcA  = REG_W'(sa);
    issueSrcB  = REG_W'(sb);
  endtask

  task automatic putBus(input int tag, input logic [DATA_W-1:0] v);
    cdbValid = 1'b1;
    cdbTag   = TAG_W'(tag);
    cdbData  = v;
  endtask

  task automatic checkWrite(input string req, input int dst, input logic [DATA_W-1:0] v);
    #1;
    check({req, " write enable"}, 32'(rfWrEn), 32'd1);
    check({req, " write addr"}, 32'(rfWrAddr), 32'(dst));
    check({req, " write data"}, 32'(rfWrData), 32'(v));
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    for (int r = 0; r < NUM_REGS; r++) begin
      rfMem[r] = DATA_W'(r * 16'h0111 + 5);
      expRf[r] = DATA_W'(r * 16'h0111 + 5);
    end
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    #2;
    // R11 reset state
    check("R11 issueReady", 32'(issueReady), 32'd1);
    check("R11 dispValid", 32'(dispValid), 32'd0);
    check("R11 rfWrEn", 32'(rfWrEn), 32'd0);

    // R3 R2 R5 R8: sweep every source-register pair through the pool.
    for (int sa = 0; sa < NUM_REGS; sa++) begin
      for (int sb = 0; sb < NUM_REGS; sb++) begin
        int op  = (sa + sb) % 4;
        int dst = (sa * 3 + sb) % NUM_REGS;
        logic [DATA_W-1:0] v = DATA_W'(sa * 256 + sb * 7 + 1);
        putIssue(op, dst, sa, sb);
        stepClr();
        #2;
        check("R5 sweep dispValid", 32'(dispValid), 32'd1);
        check("R2 sweep dispTag", 32'(dispTag), 32'd1);
        check("R3 sweep opA", 32'(dispOpA), 32'(expRf[sa]));
        check("R3 sweep opB", 32'(dispOpB), 32'(expRf[sb]));
        check("R5 sweep op", 32'(dispOp), 32'(op));
        stepClr();
        #2;
        check("R5 sweep dispatched once", 32'(dispValid), 32'd0);
        putBus(1, v);
        checkWrite("R8 sweep", dst, v);
        stepClr();
        expRf[dst] = v;
      end
    end

    // R4 R9 R8: dependency and overtaken producer.
    putIssue(0, 2, 0, 1);                  // tag1 writes r2
    stepClr();
    putIssue(1, 5, 2, 3);                  // tag2 reads r2 -> waits on tag1
    stepClr();
    #2;
    check("R4 waiting consumer not dispatched", 32'(dispValid), 32'd0);
    putIssue(2, 2, 0, 0);                  // tag3 renames r2 again
    stepClr();
    #2;
    check("R9 newer writer dispatches", 32'(dispTag), 32'd3);
    putBus(1, 16'hAAAA);
    #1;
    check("R8 overtaken producer no write", 32'(rfWrEn), 32'd0);
    stepClr();
    #2;
    check("R4 captured dispValid", 32'(dispValid), 32'd1);
    check("R4 captured dispTag", 32'(dispTag), 32'd2);
    check("R4 captured opA", 32'(dispOpA), 32'hAAAA);
    check("R4 ready opB", 32'(dispOpB), 32'(expRf[3]));
    stepClr();
    putBus(3, 16'h5555);
    checkWrite("R9 last writer", 2, 16'h5555);
    stepClr();
    expRf[2] = 16'h5555;
    putBus(2, 16'h1234);
    checkWrite("R8 consumer result", 5, 16'h1234);
    stepClr();
    expRf[5] = 16'h1234;

    // R7: broadcast in the same cycle as a dependent issue.
    putIssue(3, 4, 0, 0);                  // tag1 writes r4
    stepClr();
    stepClr();
    putIssue(0, 6, 4, 4);                  // tag2 reads r4 while tag1 broadcasts
    putBus(1, 16'h0F0F);
    checkWrite("R7 producer", 4, 16'h0F0F);
    stepClr();
    expRf[4] = 16'h0F0F;
    #2;
    check("R7 dispValid", 32'(dispValid), 32'd1);
    check("R2 lowest free tag", 32'(dispTag), 32'd2);
    check("R7 opA bypass", 32'(dispOpA), 32'h0F0F);
    check("R7 opB bypass", 32'(dispOpB), 32'h0F0F);
    stepClr();
    putBus(2, 16'hBEEF);
    checkWrite("R7 consumer", 6, 16'hBEEF);
    stepClr();
    expRf[6] = 16'hBEEF;

    // R1 R10 R6: fill the pool, stall, release, and ordered dispatch.
    putIssue(1, 7, 0, 0);                  // tag1 -> r7
    stepClr();
    putIssue(2, 1, 7, 0);                  // tag2
    stepClr();
    putIssue(3, 3, 7, 7);                  // tag3
    stepClr();
    putIssue(0, 6, 0, 7);                  // tag4
    stepClr();
    #2;
    check("R1 full issueReady", 32'(issueReady), 32'd0);
    check("R6 all waiting", 32'(dispValid), 32'd0);
    putIssue(1, 0, 1, 1);                  // must be ignored
    stepClr();
    #2;
    check("R1 still full", 32'(issueReady), 32'd0);
    putBus(1, 16'h7777);
    checkWrite("R10 producer", 7, 16'h7777);
    stepClr();
    expRf[7] = 16'h7777;
    #2;
    check("R10 freed station", 32'(issueReady), 32'd1);
    check("R6 first of tie", 32'(dispTag), 32'd2);
    check("R6 first opA", 32'(dispOpA), 32'h7777);
    check("R6 first opB", 32'(dispOpB), 32'(expRf[0]));
    stepClr();
    #2;
    check("R6 second of tie", 32'(dispTag), 32'd3);
    check("R6 second opB", 32'(dispOpB), 32'h7777);
    stepClr();
    #2;
    check("R6 third of tie", 32'(dispTag), 32'd4);
    check("R6 third opA", 32'(dispOpA), 32'(expRf[0]));
    stepClr();
    #2;
    check("R5 tie drained", 32'(dispValid), 32'd0);
    putIssue(2, 0, 0, 0);                  // r0 must not be renamed by the ignored issue
    stepClr();
    #2;
    check("R1 ignored issue left r0 ready", 32'(dispValid), 32'd1);
    check("R1 reuse tag", 32'(dispTag), 32'd1);
    check("R1 r0 value", 32'(dispOpA), 32'(expRf[0]));
    stepClr();
    putBus(1, 16'h0101);
    checkWrite("R8 drain r0", 0, 16'h0101);
    stepClr();
    putBus(2, 16'h0202);
    checkWrite("R8 drain r1", 1, 16'h0202);
    stepClr();
    putBus(3, 16'h0303);
    checkWrite("R8 drain r3", 3, 16'h0303);
    stepClr();
    putBus(4, 16'h0606);
    checkWrite("R8 drain r6", 6, 16'h0606);
    stepClr();
    #2;
    check("R10 pool empty", 32'(issueReady), 32'd1);
    check("R11 idle rfWrEn", 32'(rfWrEn), 32'd0);

    report();
    $finish;
  end

endmodule